// File: doc/BRIEF.md
# Host Bus Front End for a Character Display Controller

This block sits between an external microprocessor bus and the core of a character display controller. A static mode pin picks one of two bus protocols. In the first, a direction line and a high-active enable strobe define the cycle. In the second, separate active-low write and read strobes define it. All host strobes are brought into the system clock through a synchronizer. A completed transfer is then acted on inside the clock domain.

A register-select line steers each cycle. A write with the line low becomes a one-cycle instruction strobe to the core. A write with the line high becomes a one-cycle RAM write request carrying the byte. Reads with the line low return a status byte, made of the busy flag and the address counter. Reads with the line high return an output register that is refilled by a RAM prefetch after every data byte read. Because of this prefetch, the first read after an address change returns stale data, so the host discards one dummy read.

The bus runs 8 bits wide or, after a width instruction, 4 bits wide on the upper data lines. In the 4-bit case each byte moves as two transfers, upper half first.

Top module: `hostbus_fe`

## Requirements
- R1: With `bus_proto` = 1, `bus_ctl_a` is the direction line (1 = read, 0 = write) and `bus_ctl_b` is a high-active enable. A write is taken when the enable falls, and a read cycle lasts while the enable is high with the direction line at 1.
- R2: With `bus_proto` = 0, `bus_ctl_a` is an active-low write strobe and `bus_ctl_b` is an active-low read strobe. A write is taken when the write strobe rises, and a read cycle lasts while the read strobe is low.
- R3: While `bus_cs_n` is high, strobes cause no instruction strobe, no RAM write request, no RAM read request, and `bus_doe` stays 0.
- R4: A completed byte written with `bus_rs` = 0 produces one `instr_valid` pulse carrying the byte on `instr_code`. A completed byte written with `bus_rs` = 1 produces one `ram_wr_req` pulse carrying the byte on `ram_wr_data`.
- R5: Bus width comes out of reset as 8 bits. An instruction whose bits 7..5 are 001 sets the width from its bit 4 (1 = 8 bits, 0 = 4 bits), and the new width applies from the next transfer.
- R6: In 4-bit width each byte takes two transfers on data lines 7..4, the upper half first, for both writes and reads.
- R7: In 4-bit width, `bus_din[3:0]` is ignored and `bus_doe` during a read is 8'hF0. In 8-bit width it is 8'hFF.
- R8: After reset, and after any width instruction, the next transfer is taken as the upper half of a byte.
- R9: A read with `bus_rs` = 0 returns {`stat_busy`, `stat_ac`}, latched at the start of the byte's first transfer. In 4-bit width both halves come from that one latched value.
- R10: A read with `bus_rs` = 1 returns the output register, which resets to 0. Each completed data byte read issues one `ram_rd_req` pulse, and the output register loads `ram_rd_data` in the following cycle.
- R11: After an address-set instruction, the first data byte read (one transfer in 8-bit width, two in 4-bit width) returns the previous output register content. The next byte read returns the RAM content at the new address.
- R12: At most one of `instr_valid`, `ram_wr_req` and `ram_rd_req` is high in any cycle, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_proto | input | 1 | Static protocol select: 1 = direction+enable, 0 = separate strobes |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rs | input | 1 | Register select: 1 = data, 0 = instruction/status |
| bus_ctl_a | input | 1 | Direction line (proto 1) or active-low write strobe (proto 0) |
| bus_ctl_b | input | 1 | Enable (proto 1) or active-low read strobe (proto 0) |
| bus_din | input | 8 | Host data bus, input side |
| bus_dout | output | 8 | Host data bus, output side |
| bus_doe | output | 8 | Per-line output enable for the data bus |
| instr_valid | output | 1 | One-cycle instruction strobe |
| instr_code | output | 8 | Instruction byte |
| ram_wr_req | output | 1 | One-cycle RAM write request |
| ram_wr_data | output | 8 | RAM write byte |
| ram_rd_req | output | 1 | One-cycle RAM prefetch request |
| ram_rd_data | input | 8 | RAM data, valid the cycle after a request |
| stat_busy | input | 1 | Busy flag from the core |
| stat_ac | input | 7 | Address counter from the core |

## Verification
The properties assume the host behaves as a well-formed bus master. They assume chip select, register select and data stay steady for several clocks around every strobe edge. They assume strobe pulses and gaps last longer than the synchronizer depth, so no two transfer events land close together. They also assume `bus_proto` changes only under reset. The stimulus respects all of this: every transfer is built by one task that sets up select and data, waits, pulses the strobe for seven clocks, holds everything six more clocks and then releases. The protocol changes only between resets.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HALF_W    = BYTE_W / 2;
  localparam int unsigned WIDTH_BIT = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic {
    PROTO_STROBES = 1'b0,
    PROTO_DIR_EN  = 1'b1
  } proto_e;

  function automatic logic is_width_cmd(input byte_t code);
    return code[BYTE_W-1:BYTE_W-3] == 3'b001;
  endfunction
endpackage

// File: rtl/hbf_sync_edge.sv
`timescale 1ns/1ps
module hbf_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end else begin : g_single
      always_comb chain_d = async_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[TOP];
    end
  end

  assign level = last_q;
  assign rise  = chain_q[TOP] & ~last_q;
  assign fall  = ~chain_q[TOP] & last_q;
endmodule

// File: rtl/hbf_xfer_ctl.sv
`timescale 1ns/1ps
module hbf_xfer_ctl
  import hbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_done,
  input  logic  rd_start,
  input  logic  rd_done,
  input  logic  rs,
  input  byte_t din,
  output logic  width8,
  output logic  phase_hi,
  output logic  instr_valid,
  output byte_t instr_code,
  output logic  ram_wr_req,
  output byte_t ram_wr_data,
  output logic  ram_rd_req
);
  logic  width_q, width_d;
  logic  phase_q, phase_d;
  half_t hold_q, hold_d;
  logic  rdrs_q, rdrs_d;
  logic  iv_q, iv_d;
  byte_t code_q, code_d;
  logic  wv_q, wv_d;
  byte_t wdat_q, wdat_d;
  logic  rv_q, rv_d;
  logic  byte_done;
  byte_t byte_val;

  always_comb begin
    width_d   = width_q;
    phase_d   = phase_q;
    hold_d    = hold_q;
    rdrs_d    = rdrs_q;
    code_d    = code_q;
    wdat_d    = wdat_q;
    iv_d      = 1'b0;
    wv_d      = 1'b0;
    rv_d      = 1'b0;
    byte_done = 1'b0;
    byte_val  = din;
    if (rd_start) rdrs_d = rs;
    if (wr_done) begin
      if (width_q) begin
        byte_done = 1'b1;
      end else if (phase_q) begin
        hold_d  = din[BYTE_W-1:HALF_W];
        phase_d = 1'b0;
      end else begin
        byte_val  = {hold_q, din[BYTE_W-1:HALF_W]};
        byte_done = 1'b1;
        phase_d   = 1'b1;
      end
      if (byte_done) begin
        if (rs) begin
          wv_d   = 1'b1;
          wdat_d = byte_val;
        end else begin
          iv_d   = 1'b1;
          code_d = byte_val;
          if (is_width_cmd(byte_val)) begin
            width_d = byte_val[WIDTH_BIT];
            phase_d = 1'b1;
          end
        end
      end
    end else if (rd_done) begin
      if (width_q) begin
        rv_d = rdrs_q;
      end else if (phase_q) begin
        phase_d = 1'b0;
      end else begin
        phase_d = 1'b1;
        rv_d    = rdrs_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= 1'b1;
      phase_q <= 1'b1;
      hold_q  <= '0;
      rdrs_q  <= 1'b0;
      iv_q    <= 1'b0;
      code_q  <= '0;
      wv_q    <= 1'b0;
      wdat_q  <= '0;
      rv_q    <= 1'b0;
    end else begin
      width_q <= width_d;
      phase_q <= phase_d;
      hold_q  <= hold_d;
      rdrs_q  <= rdrs_d;
      iv_q    <= iv_d;
      code_q  <= code_d;
      wv_q    <= wv_d;
      wdat_q  <= wdat_d;
      rv_q    <= rv_d;
    end
  end

  assign width8      = width_q;
  assign phase_hi    = phase_q;
  assign instr_valid = iv_q;
  assign instr_code  = code_q;
  assign ram_wr_req  = wv_q;
  assign ram_wr_data = wdat_q;
  assign ram_rd_req  = rv_q;
endmodule

// File: rtl/hbf_read_port.sv
`timescale 1ns/1ps
module hbf_read_port
  import hbf_pkg::*;
#(
  parameter int unsigned AC_W = BYTE_W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_start,
  input  logic            rd_level,
  input  logic            rs,
  input  logic            width8,
  input  logic            phase_hi,
  input  logic            stat_busy,
  input  logic [AC_W-1:0] stat_ac,
  input  logic            ram_rd_req,
  input  byte_t           ram_rd_data,
  output byte_t           bus_dout,
  output byte_t           bus_doe
);
  byte_t out_q, out_d;
  byte_t drv_q, drv_d;
  logic  pend_q;
  half_t half_sel;

  always_comb begin
    out_d = out_q;
    drv_d = drv_q;
    if (pend_q) out_d = ram_rd_data;
    if (rd_start && (width8 || phase_hi)) begin
      drv_d = rs ? out_q : {stat_busy, stat_ac};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      drv_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      drv_q  <= drv_d;
      pend_q <= ram_rd_req;
    end
  end

  always_comb begin
    half_sel = phase_hi ? drv_q[BYTE_W-1:HALF_W] : drv_q[HALF_W-1:0];
    if (width8) begin
      bus_dout = drv_q;
      bus_doe  = rd_level ? '1 : '0;
    end else begin
      bus_dout = {half_sel, {HALF_W{1'b0}}};
      bus_doe  = rd_level ? {{HALF_W{1'b1}}, {HALF_W{1'b0}}} : '0;
    end
  end
endmodule

// File: rtl/hostbus_fe.sv
`timescale 1ns/1ps
module hostbus_fe
  import hbf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_proto,
  input  logic       bus_cs_n,
  input  logic       bus_rs,
  input  logic       bus_ctl_a,
  input  logic       bus_ctl_b,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic [7:0] bus_doe,
  output logic       instr_valid,
  output logic [7:0] instr_code,
  output logic       ram_wr_req,
  output logic [7:0] ram_wr_data,
  output logic       ram_rd_req,
  input  logic [7:0] ram_rd_data,
  input  logic       stat_busy,
  input  logic [6:0] stat_ac
);
  localparam int unsigned AC_W  = BYTE_W - 1;
  localparam int unsigned N_DIR = 2;
  localparam int unsigned IDX_W = 0;
  localparam int unsigned IDX_R = 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [N_DIR-1:0] act_raw, act_lvl, act_rise, act_fall;
  logic             width8, phase_hi;
  proto_e           proto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign proto = proto_e'(bus_proto);

  always_comb begin
    if (proto == PROTO_DIR_EN) begin
      act_raw[IDX_W] = ~bus_cs_n & ~bus_ctl_a & bus_ctl_b;
      act_raw[IDX_R] = ~bus_cs_n &  bus_ctl_a & bus_ctl_b;
    end else begin
      act_raw[IDX_W] = ~bus_cs_n & ~bus_ctl_a;
      act_raw[IDX_R] = ~bus_cs_n & ~bus_ctl_b;
    end
  end

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_sync
      hbf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .async_in (act_raw[g]),
        .level    (act_lvl[g]),
        .rise     (act_rise[g]),
        .fall     (act_fall[g])
      );
    end
  endgenerate

  hbf_xfer_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_done     (act_fall[IDX_W]),
    .rd_start    (act_rise[IDX_R]),
    .rd_done     (act_fall[IDX_R]),
    .rs          (bus_rs),
    .din         (bus_din),
    .width8      (width8),
    .phase_hi    (phase_hi),
    .instr_valid (instr_valid),
    .instr_code  (instr_code),
    .ram_wr_req  (ram_wr_req),
    .ram_wr_data (ram_wr_data),
    .ram_rd_req  (ram_rd_req)
  );

  hbf_read_port #(.AC_W(AC_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .rd_start    (act_rise[IDX_R]),
    .rd_level    (act_lvl[IDX_R]),
    .rs          (bus_rs),
    .width8      (width8),
    .phase_hi    (phase_hi),
    .stat_busy   (stat_busy),
    .stat_ac     (stat_ac),
    .ram_rd_req  (ram_rd_req),
    .ram_rd_data (ram_rd_data),
    .bus_dout    (bus_dout),
    .bus_doe     (bus_doe)
  );

  logic unused_lvl_w;
  assign unused_lvl_w = act_lvl[IDX_W] | act_rise[IDX_W];
endmodule

// File: rtl/hbf_checker.sv
`timescale 1ns/1ps
module hbf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_valid,
  input logic       ram_wr_req,
  input logic       ram_rd_req,
  input logic [7:0] bus_doe,
  input logic       width8,
  input logic       phase_hi
);
  assert_one_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_valid, ram_wr_req, ram_rd_req}));

  assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_req |=> !ram_wr_req);

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_req |=> !ram_rd_req);

  assert_low_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_doe[3:0]) |-> width8);

  assert_doe_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe == 8'h00) || (bus_doe == 8'hFF) || (bus_doe == 8'hF0));

  assert_phase_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> phase_hi);
endmodule

bind hostbus_fe hbf_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .ram_wr_req  (ram_wr_req),
  .ram_rd_req  (ram_rd_req),
  .bus_doe     (bus_doe),
  .width8      (width8),
  .phase_hi    (phase_hi)
);

// File: tb/sim_hostbus_fe.sv
`timescale 1ns/1ps
module sim_hostbus_fe;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_proto, bus_cs_n, bus_rs, bus_ctl_a, bus_ctl_b;
  logic [7:0] bus_din, bus_dout, bus_doe;
  logic       instr_valid, ram_wr_req, ram_rd_req;
  logic [7:0] instr_code, ram_wr_data, ram_rd_data;
  logic       stat_busy;
  logic [6:0] stat_ac;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] m_ac;
  logic [7:0] rdq;
  int n_wr = 0, n_iv = 0, n_rd = 0;
  logic [7:0] last_code;
  bit w8;

  always #4 clk = ~clk;

  hostbus_fe u0 (
    .clk(clk), .rst_n(rst_n), .bus_proto(bus_proto), .bus_cs_n(bus_cs_n),
    .bus_rs(bus_rs), .bus_ctl_a(bus_ctl_a), .bus_ctl_b(bus_ctl_b),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .instr_valid(instr_valid), .instr_code(instr_code),
    .ram_wr_req(ram_wr_req), .ram_wr_data(ram_wr_data),
    .ram_rd_req(ram_rd_req), .ram_rd_data(ram_rd_data),
    .stat_busy(stat_busy), .stat_ac(stat_ac)
  );

  assign ram_rd_data = rdq;
  assign stat_ac     = m_ac;

  // RAM and address counter model of the core side
  always @(posedge clk) begin
    if (ram_wr_req) begin
      mem[m_ac] <= ram_wr_data;
      m_ac <= m_ac + 7'd1;
      n_wr <= n_wr + 1;
    end
    if (instr_valid) begin
      n_iv <= n_iv + 1;
      last_code <= instr_code;
      if (instr_code[7]) m_ac <= instr_code[6:0];
    end
    if (ram_rd_req) begin
      rdq <= mem[m_ac];
      m_ac <= m_ac + 7'd1;
      n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    bus_cs_n = 1'b1;
    if (bus_proto) begin bus_ctl_a = 1'b1; bus_ctl_b = 1'b0; end
    else           begin bus_ctl_a = 1'b1; bus_ctl_b = 1'b1; end
  endtask

  task automatic xfer(input bit is_rd, input bit sel_n, input bit rsv,
                      input logic [7:0] d, output logic [7:0] q, output logic [7:0] oe);
    @(negedge clk);
    bus_cs_n = sel_n; bus_rs = rsv; bus_din = d;
    if (bus_proto) bus_ctl_a = is_rd;
    repeat (2) @(negedge clk);
    if (bus_proto)  bus_ctl_b = 1'b1;
    else if (is_rd) bus_ctl_b = 1'b0;
    else            bus_ctl_a = 1'b0;
    repeat (7) @(negedge clk);
    q = bus_dout; oe = bus_doe;
    if (bus_proto) bus_ctl_b = 1'b0;
    else begin bus_ctl_a = 1'b1; bus_ctl_b = 1'b1; end
    repeat (6) @(negedge clk);
    idle_pins();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_byte(input bit rsv, input logic [7:0] b);
    logic [7:0] q, oe;
    if (w8) xfer(1'b0, 1'b0, rsv, b, q, oe);
    else begin
      // low lines carry junk: R7
      xfer(1'b0, 1'b0, rsv, {b[7:4], 4'hA}, q, oe);
      xfer(1'b0, 1'b0, rsv, {b[3:0], 4'h5}, q, oe);
    end
    if (!rsv && b[7:5] == 3'b001) w8 = b[4];
  endtask

  task automatic rd_byte(input bit rsv, input string tag, output logic [7:0] r);
    logic [7:0] q1, q2, oe1, oe2;
    if (w8) begin
      xfer(1'b1, 1'b0, rsv, 8'h00, q1, oe1);
      chk({tag, " R7 doe8"}, oe1, 8'hFF);
      r = q1;
    end else begin
      xfer(1'b1, 1'b0, rsv, 8'h00, q1, oe1);
      xfer(1'b1, 1'b0, rsv, 8'h00, q2, oe2);
      chk({tag, " R7 doe4a"}, oe1, 8'hF0);
      chk({tag, " R7 doe4b"}, oe2, 8'hF0);
      r = {q1[7:4], q2[7:4]};
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_pins();
    bus_rs = 1'b0; bus_din = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    w8 = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    m_ac = '0; rdq = '0; last_code = '0;
    stat_busy = 1'b0;
    bus_proto = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit p, w4;
      string pt;
      int base, n0;
      logic [7:0] r, q, oe;
      p = cfg[1]; w4 = cfg[0];
      pt = p ? "R1" : "R2";
      base = cfg * 20;
      bus_proto = p;
      do_reset();
      // reset state
      chk({pt, " reset doe R10"}, bus_doe, 8'h00);
      chk({pt, " reset pulses R12"}, {5'd0, instr_valid, ram_wr_req, ram_rd_req}, 8'h00);
      if (w4) begin
        n0 = n_iv;
        wr_byte(1'b0, 8'h20);   // width 4: R5
        chk_int({pt, " R5 width cmd count"}, n_iv - n0, 1);
        chk({pt, " R5 width cmd code"}, last_code, 8'h20);
      end
      // address set then data writes (R4, R6, R8)
      n0 = n_iv;
      wr_byte(1'b0, 8'h80 | 8'(base));
      chk_int({pt, " R4 instr count"}, n_iv - n0, 1);
      chk({pt, " R4 instr code R8"}, last_code, 8'h80 | 8'(base));
      n0 = n_wr;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] d;
        d = 8'((i * 37 + cfg * 11 + 5) & 255);
        wr_byte(1'b1, d);
        exp_mem[base + i] = d;
      end
      chk_int({pt, " R4 data write count"}, n_wr - n0, 16);
      // status reads (R9)
      for (int b = 0; b < 2; b++) begin
        stat_busy = b[0];
        rd_byte(1'b0, pt, r);
        chk({pt, " R9 status"}, r, {b[0], 7'(base + 16)});
      end
      stat_busy = 1'b0;
      // readback with dummy (R11, R10, R6)
      wr_byte(1'b0, 8'h80 | 8'(base));
      n0 = n_rd;
      rd_byte(1'b1, pt, r);
      chk({pt, " R11 dummy after reset"}, r, 8'h00);
      for (int i = 0; i < 16; i++) begin
        rd_byte(1'b1, pt, r);
        chk({pt, " R10 R6 readback"}, r, exp_mem[base + i]);
      end
      chk_int({pt, " R10 prefetch count"}, n_rd - n0, 17);
      wr_byte(1'b0, 8'h80 | 8'(base + 3));
      rd_byte(1'b1, pt, r);
      chk({pt, " R11 dummy stale"}, r, exp_mem[base + 16]);
      rd_byte(1'b1, pt, r);
      chk({pt, " R11 valid after dummy"}, r, exp_mem[base + 3]);
      // chip select high (R3)
      n0 = n_wr + n_iv + n_rd;
      xfer(1'b0, 1'b1, 1'b1, 8'hC3, q, oe);
      xfer(1'b0, 1'b1, 1'b0, 8'h80, q, oe);
      xfer(1'b1, 1'b1, 1'b1, 8'h00, q, oe);
      chk({pt, " R3 no drive"}, oe, 8'h00);
      chk_int({pt, " R3 no pulses"}, n_wr + n_iv + n_rd - n0, 0);
      chk_int({pt, " R3 ac kept"}, int'(m_ac), base + 5);
      if (w4) begin
        // back to 8 bits (R5, R8)
        wr_byte(1'b0, 8'h30);
        wr_byte(1'b0, 8'h80 | 8'(base + 17));
        wr_byte(1'b1, 8'h5A);
        exp_mem[base + 17] = 8'h5A;
        wr_byte(1'b0, 8'h80 | 8'(base + 17));
        rd_byte(1'b1, pt, r);
        rd_byte(1'b1, pt, r);
        chk({pt, " R5 R8 back to 8-bit"}, r, 8'h5A);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule